// File: doc/BRIEF.md
# Loop Divider, Phase Comparator and Lock Flag

This block is the digital heart of a frequency synthesiser's phase-locked loop. It runs on one fast system clock and sees the two loop clocks as single-cycle tick strobes. The first strobe comes from the local oscillator after an external divide-by-8 prescaler. The second comes from the reference oscillator. The ticks from the oscillator are divided by a programmable 15-bit ratio. The reference ticks are divided by a fixed 512, which gives the comparison rate. With a 4 MHz reference this rate is 7.8125 kHz, and the oscillator then settles at ratio × 8 × comparison frequency.

A two-flip-flop phase-frequency detector turns the two divided pulse trains into pump-up and pump-down requests. A lock detector watches how wide those requests are in each comparison period and raises a lock flag. Four control bits, registered once on entry, do the following:
- One gates the pump requests off.
- One selects the pump current level.
- One turns the tuning amplifier off.
- One replaces the values of two general-purpose port pins with the divided comparison pulse and the divided oscillator pulse, for test.

Top module: `pll_loop_core`

## Requirements
- R1: With ratio N ≥ 1, the variable divider gives one divided pulse for every N oscillator ticks. A ratio of 0 behaves as a ratio of 1.
- R2: A ratio change takes effect only when the divider reaches terminal count. The interval in progress finishes at the old ratio, and the next interval uses the new ratio.
- R3: The reference divider gives one comparison pulse for every 512 reference ticks.
- R4: The internal up request rises the cycle after a comparison pulse, and the down request rises the cycle after a divided pulse. When both would be set together, both are cleared. Up and down are never active at the same time.
- R5: While the registered pump-off bit is 1, `pump_up_o` and `pump_dn_o` are both 0. The bit is registered one cycle after `pump_off_i`.
- R6: `hi_cur_o` follows `hi_cur_i`, and `amp_off_o` follows `amp_off_i`, each one cycle late. A value of 1 means high pump current and amplifier off, respectively.
- R7: When the registered test-route bit is 1, `pin6_o` carries the comparison pulse and `pin7_o` carries the divided pulse. Otherwise the pins carry `port6_i` and `port7_i`.
- R8: The lock flag rises at the end of the 4th consecutive comparison period in which no up or down request stayed active for 16 or more consecutive cycles. A period ends on a comparison pulse.
- R9: The lock flag falls at the end of the first comparison period that fails the width test. The count of good periods then restarts from zero.
- R10: During and right after a synchronous reset, the pump outputs, current select, amplifier-off and lock outputs are 0, and the pins carry the port inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_tick_i | input | 1 | One-cycle strobe per prescaled oscillator edge |
| ref_tick_i | input | 1 | One-cycle strobe per reference oscillator edge |
| ratio_i | input | 15 | Programmable division ratio |
| hi_cur_i | input | 1 | Pump current select, 1 = high |
| pump_off_i | input | 1 | 1 = gate pump requests off |
| test_route_i | input | 1 | 1 = route divided pulses to the pins |
| amp_off_i | input | 1 | 1 = tuning amplifier off |
| port6_i | input | 1 | Normal value of pin 6 |
| port7_i | input | 1 | Normal value of pin 7 |
| pump_up_o | output | 1 | Pump-up request |
| pump_dn_o | output | 1 | Pump-down request |
| hi_cur_o | output | 1 | Registered current select |
| amp_off_o | output | 1 | Registered amplifier disable |
| pin6_o | output | 1 | Pin 6 value (port or comparison pulse) |
| pin7_o | output | 1 | Pin 7 value (port or divided pulse) |
| lock_o | output | 1 | Phase lock flag |

## Verification
The hardest case to reach is a change of ratio in the middle of a count, together with the loss of lock that follows it. Both depend on divider phase that the ports do not show.

The bench routes the divided pulse to pin 7 and waits for a pulse there. It changes the ratio a few cycles later and times that interval and the one after it.

To reach lock and then loss of lock, the bench first runs both dividers in phase until four good periods have passed. It then detunes the ratio slightly, so the phase error grows by a fixed amount each period until the pulse width crosses the tolerance. A cycle-by-cycle behavioural model, compared on every clock, covers everything in between.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

    typedef struct packed {
        logic hi_cur;
        logic pump_off;
        logic test_route;
        logic amp_off;
    } loop_ctl_t;

endpackage

// File: rtl/pll_tick_divider.sv
module pll_tick_divider #(
    parameter int CNT_W   = 15,
    parameter bit FIXED   = 1'b0,
    parameter int FIXED_N = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             pulse
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] reload;

    generate
        if (FIXED) begin : g_fixed
            assign reload = CNT_W'(FIXED_N - 1);
            logic unused_ratio;
            assign unused_ratio = ^ratio;
        end else begin : g_var
            // a ratio of zero reloads zero, i.e. divide by one
            assign reload = (ratio == '0) ? '0 : ratio - CNT_W'(1);
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt   = reload;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R1 R3
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> $past(tick));

    // R2
    count_steps_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.cnt != '0) |=> st_q.cnt == CNT_W'($past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
    input  logic clk,
    input  logic rst,
    input  logic ref_p,
    input  logic div_p,
    output logic up,
    output logic dn
);

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_p;
        st_d.dn = st_q.dn | div_p;
        if (st_d.up && st_d.dn) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    // R4
    up_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_p && !div_p && !st_q.dn) |=> st_q.up);

    // R4
    dn_on_div_chk: assert property (@(posedge clk) disable iff (rst)
        (div_p && !ref_p && !st_q.up) |=> st_q.dn);

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
    parameter int TOL    = 16,
    parameter int NGOOD  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic up,
    input  logic dn,
    input  logic period_end,
    output logic locked
);

    localparam int WID_W  = $clog2(TOL + 1);
    localparam int GOOD_W = $clog2(NGOOD + 1);

    typedef struct packed {
        logic [WID_W-1:0]  wid;
        logic [GOOD_W-1:0] good;
        logic              fail;
        logic              locked;
    } lock_st_t;

    lock_st_t          st_d, st_q;
    logic              active;
    logic              cur_fail;
    logic              per_fail;
    logic [GOOD_W-1:0] good_inc;

    always_comb begin
        st_d   = st_q;
        active = up | dn;
        if (active) begin
            st_d.wid = (st_q.wid == WID_W'(TOL)) ? st_q.wid : st_q.wid + WID_W'(1);
        end else begin
            st_d.wid = '0;
        end
        cur_fail = active && (st_d.wid >= WID_W'(TOL));
        per_fail = st_q.fail | cur_fail;
        good_inc = (st_q.good == GOOD_W'(NGOOD)) ? st_q.good : st_q.good + GOOD_W'(1);
        if (period_end) begin
            st_d.fail = 1'b0;
            if (per_fail) begin
                st_d.good   = '0;
                st_d.locked = 1'b0;
            end else begin
                st_d.good   = good_inc;
                st_d.locked = (good_inc == GOOD_W'(NGOOD));
            end
        end else begin
            st_d.fail = per_fail;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked = st_q.locked;

    // R8
    lock_rise_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.locked) |-> $past(period_end));

    // R9
    lock_fall_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.locked) |-> $past(period_end));

endmodule

// File: rtl/pll_loop_core.sv
module pll_loop_core #(
    parameter int RATIO_W      = 15,
    parameter int REF_DIV      = 512,
    parameter int LOCK_TOL     = 16,
    parameter int LOCK_PERIODS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lo_tick_i,
    input  logic               ref_tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               hi_cur_i,
    input  logic               pump_off_i,
    input  logic               test_route_i,
    input  logic               amp_off_i,
    input  logic               port6_i,
    input  logic               port7_i,
    output logic               pump_up_o,
    output logic               pump_dn_o,
    output logic               hi_cur_o,
    output logic               amp_off_o,
    output logic               pin6_o,
    output logic               pin7_o,
    output logic               lock_o
);

    import pll_core_pkg::*;

    localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    loop_ctl_t ctl_d, ctl_q;
    logic      fcomp_p;
    logic      fdiv_p;
    logic      up_int;
    logic      dn_int;

    always_comb begin
        ctl_d.hi_cur     = hi_cur_i;
        ctl_d.pump_off   = pump_off_i;
        ctl_d.test_route = test_route_i;
        ctl_d.amp_off    = amp_off_i;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    pll_tick_divider #(
        .CNT_W   (REF_W),
        .FIXED   (1'b1),
        .FIXED_N (REF_DIV)
    ) u_ref_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (ref_tick_i),
        .ratio ('0),
        .pulse (fcomp_p)
    );

    pll_tick_divider #(
        .CNT_W   (RATIO_W),
        .FIXED   (1'b0),
        .FIXED_N (1)
    ) u_var_div (
        .clk   (clk),
        .rst   (rst),
        .tick  (lo_tick_i),
        .ratio (ratio_i),
        .pulse (fdiv_p)
    );

    pll_pfd u_pfd (
        .clk   (clk),
        .rst   (rst),
        .ref_p (fcomp_p),
        .div_p (fdiv_p),
        .up    (up_int),
        .dn    (dn_int)
    );

    pll_lock_det #(
        .TOL   (LOCK_TOL),
        .NGOOD (LOCK_PERIODS)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .up         (up_int),
        .dn         (dn_int),
        .period_end (fcomp_p),
        .locked     (lock_o)
    );

    assign pump_up_o = up_int & ~ctl_q.pump_off;
    assign pump_dn_o = dn_int & ~ctl_q.pump_off;
    assign hi_cur_o  = ctl_q.hi_cur;
    assign amp_off_o = ctl_q.amp_off;
    assign pin6_o    = ctl_q.test_route ? fcomp_p : port6_i;
    assign pin7_o    = ctl_q.test_route ? fdiv_p  : port7_i;

    // R5
    pump_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pump_off_i) |-> !(pump_up_o || pump_dn_o));

    // R7
    pin7_route_chk: assert property (@(posedge clk) disable iff (rst)
        $past(test_route_i) |-> (pin7_o == fdiv_p));

    // R6
    amp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        amp_off_o == $past(amp_off_i));

endmodule

// File: tb/pll_loop_core_bench.sv
`timescale 1ns/1ps
module pll_loop_core_bench;

    localparam int REFN = 512;
    localparam int TOL  = 16;
    localparam int NG   = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        lo_tick_i, ref_tick_i;
    logic [14:0] ratio_i;
    logic        hi_cur_i, pump_off_i, test_route_i, amp_off_i, port6_i, port7_i;
    logic        pump_up_o, pump_dn_o, hi_cur_o, amp_off_o, pin6_o, pin7_o, lock_o;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;
    int lo_mode = 0;

    // reference model state
    int m_rc, m_dc, m_refp, m_divp, m_up, m_dn, m_wid, m_fail, m_good, m_lock;
    int m_hi, m_off, m_route, m_amp;

    always #5 clk = ~clk;

    pll_loop_core u_pll_loop_core (
        .clk(clk), .rst(rst), .lo_tick_i(lo_tick_i), .ref_tick_i(ref_tick_i),
        .ratio_i(ratio_i), .hi_cur_i(hi_cur_i), .pump_off_i(pump_off_i),
        .test_route_i(test_route_i), .amp_off_i(amp_off_i),
        .port6_i(port6_i), .port7_i(port7_i),
        .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .hi_cur_o(hi_cur_o),
        .amp_off_o(amp_off_o), .pin6_o(pin6_o), .pin7_o(pin7_o), .lock_o(lock_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (lo_mode == 0) lo_tick_i <= 1'b1;
        else              lo_tick_i <= ~lo_tick_i;
    end

    // behavioural model, one step per clock
    always @(posedge clk) begin
        int n_rc, n_dc, n_refp, n_divp, n_up, n_dn, n_wid, act, cf, pf, load;
        if (rst) begin
            m_rc = 0; m_dc = 0; m_refp = 0; m_divp = 0; m_up = 0; m_dn = 0;
            m_wid = 0; m_fail = 0; m_good = 0; m_lock = 0;
            m_hi = 0; m_off = 0; m_route = 0; m_amp = 0;
        end else begin
            n_rc = m_rc; n_refp = 0;
            if (ref_tick_i) begin
                if (m_rc == 0) begin n_rc = REFN - 1; n_refp = 1; end
                else n_rc = m_rc - 1;
            end
            load = (ratio_i == 0) ? 0 : int'(ratio_i) - 1;
            n_dc = m_dc; n_divp = 0;
            if (lo_tick_i) begin
                if (m_dc == 0) begin n_dc = load; n_divp = 1; end
                else n_dc = m_dc - 1;
            end
            n_up = (m_up != 0 || m_refp != 0) ? 1 : 0;
            n_dn = (m_dn != 0 || m_divp != 0) ? 1 : 0;
            if (n_up == 1 && n_dn == 1) begin n_up = 0; n_dn = 0; end
            act = (m_up != 0 || m_dn != 0) ? 1 : 0;
            n_wid = act ? ((m_wid + 1 > TOL) ? TOL : m_wid + 1) : 0;
            cf = (act != 0 && n_wid >= TOL) ? 1 : 0;
            pf = (m_fail != 0 || cf != 0) ? 1 : 0;
            if (m_refp != 0) begin
                m_fail = 0;
                if (pf != 0) begin m_good = 0; m_lock = 0; end
                else begin
                    m_good = (m_good + 1 > NG) ? NG : m_good + 1;
                    m_lock = (m_good == NG) ? 1 : 0;
                end
            end else m_fail = pf;
            m_rc = n_rc; m_dc = n_dc; m_refp = n_refp; m_divp = n_divp;
            m_up = n_up; m_dn = n_dn; m_wid = n_wid;
            m_hi = hi_cur_i; m_off = pump_off_i; m_route = test_route_i; m_amp = amp_off_i;
        end
        started = 1;
    end

    // compare every clock, away from the edge
    always @(posedge clk) begin
        int eu, ed, e6, e7;
        #4;
        if (started && !done) begin
            eu = (m_off != 0) ? 0 : m_up;
            ed = (m_off != 0) ? 0 : m_dn;
            e6 = (m_route != 0) ? m_refp : int'(port6_i);
            e7 = (m_route != 0) ? m_divp : int'(port7_i);
            chk(int'(pump_up_o) == eu, "R4 R5 model pump_up", int'(pump_up_o), eu);
            chk(int'(pump_dn_o) == ed, "R4 R5 model pump_dn", int'(pump_dn_o), ed);
            chk(int'(hi_cur_o) == m_hi && int'(amp_off_o) == m_amp, "R6 model ctl",
                {hi_cur_o, amp_off_o}, m_hi * 2 + m_amp);
            chk(int'(pin6_o) == e6 && int'(pin7_o) == e7, "R7 model pins",
                {pin6_o, pin7_o}, e6 * 2 + e7);
            chk(int'(lock_o) == m_lock, "R8 R9 model lock", int'(lock_o), m_lock);
        end
    end

    task automatic measure(input bit use7, output int n);
        int guard = 0;
        n = 0;
        @(negedge clk);
        while (!(use7 ? pin7_o : pin6_o) && guard < 5000) begin @(negedge clk); guard++; end
        do begin @(negedge clk); n++; end while (!(use7 ? pin7_o : pin6_o) && n < 5000);
    endtask

    initial begin
        int n, cnt;
        rst = 1; ref_tick_i = 1; lo_tick_i = 1; ratio_i = 15'd512;
        hi_cur_i = 0; pump_off_i = 0; test_route_i = 0; amp_off_i = 0;
        port6_i = 1; port7_i = 0;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(!pump_up_o && !pump_dn_o && !lock_o && !hi_cur_o && !amp_off_o,
            "R10 reset outputs", {pump_up_o, pump_dn_o, lock_o, hi_cur_o, amp_off_o}, 0);
        chk(pin6_o == 1'b1 && pin7_o == 1'b0, "R10 reset pins", {pin6_o, pin7_o}, 2);
        rst = 0;
        @(negedge clk);
        chk(!lock_o && !pump_up_o && !pump_dn_o, "R10 after release", {lock_o, pump_up_o}, 0);

        // R8: matched ratio, in phase
        repeat (NG * REFN + 60) @(negedge clk);
        chk(lock_o == 1'b1, "R8 lock after four good periods", lock_o, 1);
        hi_cur_i = 1; amp_off_i = 1;
        @(negedge clk); @(negedge clk);
        chk(hi_cur_o == 1'b1 && amp_off_o == 1'b1, "R6 control bits follow", {hi_cur_o, amp_off_o}, 3);
        hi_cur_i = 0;
        @(negedge clk); @(negedge clk);
        chk(hi_cur_o == 1'b0, "R6 current select back low", hi_cur_o, 0);

        // R9: detuned ratio loses lock
        ratio_i = 15'd500;
        repeat (3 * REFN) @(negedge clk);
        chk(lock_o == 1'b0, "R9 lock lost when detuned", lock_o, 0);

        // R5: pump gated off
        pump_off_i = 1; cnt = 0;
        @(negedge clk);
        repeat (1500) begin @(negedge clk); if (pump_up_o || pump_dn_o) cnt++; end
        chk(cnt == 0, "R5 no pump activity while gated", cnt, 0);
        pump_off_i = 0; cnt = 0;
        @(negedge clk);
        repeat (1100) begin
            @(negedge clk);
            if (pump_up_o || pump_dn_o) cnt++;
            if (pump_up_o && pump_dn_o) chk(0, "R4 up and down together", 1, 0);
        end
        chk(cnt > 0, "R4 pump active when ungated", cnt, 1);

        // R7 / R1 / R2 / R3: pulse routing and intervals
        test_route_i = 1; ratio_i = 15'd20;
        measure(1'b1, n);
        measure(1'b1, n);
        chk(n == 20, "R1 divide by 20", n, 20);
        measure(1'b0, n);
        chk(n == REFN, "R3 reference divides by 512", n, REFN);
        // change ratio mid-count
        n = 0;
        while (!pin7_o && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        repeat (5) begin @(negedge clk); n++; end
        ratio_i = 15'd7;
        while (!pin7_o && n < 5000) begin @(negedge clk); n++; end
        chk(n == 20, "R2 interval in progress keeps old ratio", n, 20);
        n = 0;
        do begin @(negedge clk); n++; end while (!pin7_o && n < 5000);
        chk(n == 7, "R2 new ratio after terminal count", n, 7);
        lo_mode = 1;
        measure(1'b1, n);
        measure(1'b1, n);
        chk(n == 14, "R1 ratio 7 with tick every other cycle", n, 14);
        lo_mode = 0; ratio_i = 15'd0;
        measure(1'b1, n);
        measure(1'b1, n);
        chk(n == 1, "R1 ratio zero acts as one", n, 1);
        test_route_i = 0; port7_i = 1;
        @(negedge clk); @(negedge clk);
        chk(pin7_o == 1'b1 && pin6_o == 1'b1, "R7 pins back to port values", {pin6_o, pin7_o}, 3);

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule